// File: doc/BRIEF.md
# Five-Stage Integer Pipeline with Delayed Branch and Load Interlock

This block is a small in-order integer processor core for a register-to-register instruction set with 16-bit instructions and eight 16-bit registers. An instruction is fetched in one cycle and reaches the read stage in the next. There its operands are read, its branch condition is decided and its hazards are checked. In the following stage it either computes an ALU result and writes it back, or it forms a memory address. Memory operations then spend two further cycles in a data memory pipeline. The instruction memory and the data memory are internal arrays. They are filled through an initialisation write port while the core is held in reset.

Control transfers are delayed. The instruction that follows a jump or branch is always executed, and only then does fetch continue at the target. Loads do not stall the pipeline when they issue. Instead they lock their destination register. Younger instructions keep flowing until one of them reads or overwrites a locked register, and only that instruction waits. A halt instruction stops fetch. Once the pipeline has drained, the core raises `halted`. A debug port then reads back any register or data memory word.

Top module: `risc_dslot_pipe`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), `halted` is low, every register reads zero on the debug port, and execution starts at instruction address 0.
- R2: Instruction fields are: opcode in bits 15:12, rd in bits 11:9, rs in bits 8:6, rt in bits 5:3, and a signed 6-bit immediate in bits 5:0. The opcodes are NOP=0, ADD=1, SUB=2, AND=3, OR=4, ADDI=5, LOAD=6, STORE=7, JUMP=8, BEQ=9 and HALT=15. ADD, SUB, AND and OR write rs op rt to rd, and ADDI writes rs plus the sign-extended immediate to rd, all modulo 2^16.
- R3: Register 0 always reads as zero, and any write to it, including a load, is discarded.
- R4: JUMP sets the next fetch address to bits 5:0 of the instruction. The instruction that directly follows it (the delay slot) always executes, and the instructions between the slot and the target do not.
- R5: BEQ compares registers rd and rs. When they are equal, fetch continues at the branch's own address plus the sign-extended immediate, which may be negative. The delay slot executes whether or not the branch is taken.
- R6: LOAD writes data memory word [rs + imm] into rd. STORE writes register rd into data memory word [rs + imm]. The address is taken modulo the memory depth, and the immediate is signed.
- R7: An instruction that uses a load's destination register stalls for 2 cycles if it directly follows the load, 1 cycle if one instruction lies between them, and 0 cycles if two or more lie between them. Instructions that do not use that register are never delayed.
- R8: An ALU result is available to the very next instruction without any stall.
- R9: HALT prevents every later instruction from executing. After the pipeline drains, `halted` rises and stays high until reset, and registers and memory no longer change.
- R10: When an ALU instruction after a load writes the same destination register, the register ends with the ALU result.
- R11: A load that follows a store to the same address returns the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_we | input | 1 | Initialisation write strobe |
| init_dmem | input | 1 | Initialisation target: 1 selects data memory, 0 selects instruction memory |
| init_addr | input | IAW | Initialisation word address |
| init_data | input | DW | Initialisation word |
| dbg_reg | input | 3 | Debug register select |
| dbg_reg_data | output | DW | Contents of the selected register |
| dbg_mem_addr | input | DAW | Debug data memory address |
| dbg_mem_data | output | DW | Contents of the selected data memory word |
| halted | output | 1 | Core stopped and pipeline empty |

## Verification
A lock bit that sticks or is never released shows up as a run that never halts, or as a load-use distance whose cycle count is off by the full latency. Both appear within a few cycles of the load. A missing bubble or a lost delay slot changes the register contents by the time `halted` rises. The bench therefore compares final register and memory values with arithmetic it computes itself, and it compares cycle counts between programs that differ only in how far a consumer sits from its load. Wrong forwarding or wrong branch-target arithmetic corrupts the result of the very next instruction, which the operand sweeps and the looping programs expose.

// File: rtl/risc_dslot_pipe.sv
module risc_dslot_pipe #(
  parameter int DW  = 16,
  parameter int IAW = 6,
  parameter int DAW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           init_we,
  input  logic           init_dmem,
  input  logic [IAW-1:0] init_addr,
  input  logic [DW-1:0]  init_data,
  input  logic [2:0]     dbg_reg,
  output logic [DW-1:0]  dbg_reg_data,
  input  logic [DAW-1:0] dbg_mem_addr,
  output logic [DW-1:0]  dbg_mem_data,
  output logic           halted
);

  localparam int IDEPTH = 1 << IAW;
  localparam int DDEPTH = 1 << DAW;

  localparam logic [3:0] OP_ADD  = 4'd1;
  localparam logic [3:0] OP_SUB  = 4'd2;
  localparam logic [3:0] OP_AND  = 4'd3;
  localparam logic [3:0] OP_OR   = 4'd4;
  localparam logic [3:0] OP_ADDI = 4'd5;
  localparam logic [3:0] OP_LOAD = 4'd6;
  localparam logic [3:0] OP_STOR = 4'd7;
  localparam logic [3:0] OP_JMP  = 4'd8;
  localparam logic [3:0] OP_BEQ  = 4'd9;
  localparam logic [3:0] OP_HALT = 4'd15;

  logic [15:0]   imem [IDEPTH];
  logic [DW-1:0] dmem [DDEPTH];
  logic [DW-1:0] regs [8];
  logic [7:0]    lock;

  logic [IAW-1:0] pc, f_pc;
  logic [15:0]    f_ir;
  logic           f_v, stop;

  logic           e2_v;
  logic [3:0]     e2_op;
  logic [2:0]     e2_rd;
  logic [DW-1:0]  e2_a, e2_b, e2_sd, e2_res;
  logic           e2_wr;

  logic           d1_v, d1_ld;
  logic [2:0]     d1_rd;
  logic [DAW-1:0] d1_addr;
  logic [DW-1:0]  d1_sd;

  logic           d2_v;
  logic [2:0]     d2_rd;
  logic [DW-1:0]  d2_data;

  // read stage decode
  wire [3:0] f_op = f_ir[15:12];
  wire [2:0] f_rd = f_ir[11:9];
  wire [2:0] f_rs = f_ir[8:6];
  wire [2:0] f_rt = f_ir[5:3];
  wire [DW-1:0] f_imm = {{(DW-6){f_ir[5]}}, f_ir[5:0]};

  wire is_rr    = f_op inside {OP_ADD, OP_SUB, OP_AND, OP_OR};
  wire use_rs   = is_rr | (f_op inside {OP_ADDI, OP_LOAD, OP_STOR, OP_BEQ});
  wire use_rdsrc = f_op inside {OP_STOR, OP_BEQ};
  wire wr_rd    = is_rr | (f_op inside {OP_ADDI, OP_LOAD});
  wire to_e2    = is_rr | (f_op inside {OP_ADDI, OP_LOAD, OP_STOR});

  // operand read with bypass from both write ports
  wire [DW-1:0] v_rs = (f_rs == 3'd0) ? '0 : (e2_wr && e2_rd == f_rs) ? e2_res :
                       (d2_v && d2_rd == f_rs) ? d2_data : regs[f_rs];
  wire [DW-1:0] v_rt = (f_rt == 3'd0) ? '0 : (e2_wr && e2_rd == f_rt) ? e2_res :
                       (d2_v && d2_rd == f_rt) ? d2_data : regs[f_rt];
  wire [DW-1:0] v_rd = (f_rd == 3'd0) ? '0 : (e2_wr && e2_rd == f_rd) ? e2_res :
                       (d2_v && d2_rd == f_rd) ? d2_data : regs[f_rd];

  // scoreboard
  wire [7:0] lk_clr = d2_v ? (8'd1 << d2_rd) : 8'd0;
  wire [7:0] lk_eff = lock & ~lk_clr;
  wire stall = f_v & ((use_rs & lk_eff[f_rs]) | (is_rr & lk_eff[f_rt]) |
                      ((use_rdsrc | wr_rd) & lk_eff[f_rd]));
  wire issue = f_v & ~stall;
  wire [7:0] lk_set = (issue && f_op == OP_LOAD && f_rd != 3'd0) ? (8'd1 << f_rd) : 8'd0;

  wire taken    = issue & ((f_op == OP_JMP) | (f_op == OP_BEQ && v_rd == v_rs));
  wire [IAW-1:0] target = (f_op == OP_JMP) ? f_ir[IAW-1:0] : f_pc + f_imm[IAW-1:0];
  wire halt_now = issue & (f_op == OP_HALT);

  always_ff @(posedge clk)
    if (init_we && !init_dmem) imem[init_addr] <= init_data[15:0];

  // fetch: the slot after a branch is already in flight when the target loads
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= '0; f_pc <= '0; f_ir <= '0; f_v <= 1'b0; stop <= 1'b0;
    end else if (halt_now) begin
      stop <= 1'b1; f_v <= 1'b0;
    end else if (!stall && !stop) begin
      f_ir <= imem[pc];
      f_pc <= pc;
      f_v  <= 1'b1;
      pc   <= taken ? target : pc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) e2_v <= 1'b0;
    else        e2_v <= issue & to_e2;
    e2_op <= f_op;
    e2_rd <= f_rd;
    e2_a  <= v_rs;
    e2_b  <= is_rr ? v_rt : f_imm;
    e2_sd <= v_rd;
  end

  always_comb
    case (e2_op)
      OP_SUB:  e2_res = e2_a - e2_b;
      OP_AND:  e2_res = e2_a & e2_b;
      OP_OR:   e2_res = e2_a | e2_b;
      default: e2_res = e2_a + e2_b;
    endcase

  assign e2_wr = e2_v && e2_rd != 3'd0 && !(e2_op inside {OP_LOAD, OP_STOR});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      d1_v <= 1'b0; d2_v <= 1'b0;
    end else begin
      d1_v <= e2_v && (e2_op inside {OP_LOAD, OP_STOR});
      d2_v <= d1_v && d1_ld && d1_rd != 3'd0;
    end
    d1_ld   <= e2_op == OP_LOAD;
    d1_rd   <= e2_rd;
    d1_addr <= e2_res[DAW-1:0];
    d1_sd   <= e2_sd;
    d2_rd   <= d1_rd;
    d2_data <= dmem[d1_addr];
  end

  always_ff @(posedge clk)
    if (init_we && init_dmem) dmem[init_addr[DAW-1:0]] <= init_data;
    else if (d1_v && !d1_ld)  dmem[d1_addr] <= d1_sd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) regs[i] <= '0;
      lock <= '0;
    end else begin
      if (d2_v)  regs[d2_rd] <= d2_data;
      if (e2_wr) regs[e2_rd] <= e2_res;
      lock <= (lock & ~lk_clr) | lk_set;
    end
  end

  assign halted       = stop & ~e2_v & ~d1_v & ~d2_v;
  assign dbg_reg_data = regs[dbg_reg];
  assign dbg_mem_data = dmem[dbg_mem_addr];

  p_r0_zero_r3: assert property (@(posedge clk) disable iff (!rst_n) regs[0] == '0);
  p_stall_needs_lock_r7: assert property (@(posedge clk) disable iff (!rst_n) stall |-> lock != 8'd0);
  p_stall_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (pc == $past(pc) && f_ir == $past(f_ir)));
  p_stall_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n) stall |=> !e2_v);
  p_wb_was_locked_r6: assert property (@(posedge clk) disable iff (!rst_n) d2_v |-> lock[d2_rd]);
  p_single_writer_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(d2_v && e2_wr && d2_rd == e2_rd));
  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n) halted |=> halted);
  p_halt_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n) halted |=> $stable(pc));

endmodule

// File: tb/test_risc_dslot_pipe.sv
module test_risc_dslot_pipe;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init_we = 1'b0, init_dmem = 1'b0;
  logic [5:0]  init_addr = '0;
  logic [15:0] init_data = '0;
  logic [2:0]  dbg_reg = '0;
  logic [15:0] dbg_reg_data, dbg_mem_data;
  logic [5:0]  dbg_mem_addr = '0;
  logic        halted;

  int checks = 0, failures = 0;
  logic [15:0] prog [64];

  always #10 clk = ~clk;

  risc_dslot_pipe i_risc_dslot_pipe (
    .clk(clk), .rst_n(rst_n), .init_we(init_we), .init_dmem(init_dmem),
    .init_addr(init_addr), .init_data(init_data), .dbg_reg(dbg_reg),
    .dbg_reg_data(dbg_reg_data), .dbg_mem_addr(dbg_mem_addr),
    .dbg_mem_data(dbg_mem_data), .halted(halted));

  localparam logic [3:0] ADD = 1, SUB = 2, AND_ = 3, OR_ = 4, ADDI = 5, LD = 6, ST = 7, BEQ = 9;
  localparam logic [15:0] HALT = 16'hF000;

  function automatic logic [15:0] rr(logic [3:0] op, int d, int s, int t);
    return {op, d[2:0], s[2:0], t[2:0], 3'b000};
  endfunction
  function automatic logic [15:0] ri(logic [3:0] op, int d, int s, int imm);
    return {op, d[2:0], s[2:0], imm[5:0]};
  endfunction
  function automatic logic [15:0] jp(int tgt);
    return {4'd8, tgt[11:0]};
  endfunction
  function automatic int mval(int k);
    return (k * 3 + 1) & 16'hFFFF;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    for (int k = 0; k < 64; k++) prog[k] = 16'h0000;
  endtask

  task automatic run(output int cyc);
    @(negedge clk);
    rst_n = 1'b0;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      init_we = 1'b1; init_dmem = 1'b0; init_addr = k[5:0]; init_data = prog[k];
    end
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      init_we = 1'b1; init_dmem = 1'b1; init_addr = k[5:0]; init_data = mval(k)[15:0];
    end
    @(negedge clk);
    init_we = 1'b0;
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 500) begin
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 500) chk("run halts", 0, 1);
  endtask

  task automatic rdreg(int r, output int v);
    dbg_reg = r[2:0];
    #1 v = int'(dbg_reg_data);
  endtask
  task automatic rdmem(int a, output int v);
    dbg_mem_addr = a[5:0];
    #1 v = int'(dbg_mem_data);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cyc, v, ca, cb, cc, cd, cf, cg;

    // R2, R8: operand sweep, each result consumed forwarding-style
    for (int a = -32; a < 32; a += 7) begin
      for (int b = -32; b < 32; b += 7) begin
        clear_prog();
        prog[0] = ri(ADDI, 1, 0, a);
        prog[1] = ri(ADDI, 2, 0, b);
        prog[2] = rr(ADD, 3, 1, 2);
        prog[3] = rr(SUB, 4, 1, 2);
        prog[4] = rr(AND_, 5, 1, 2);
        prog[5] = rr(OR_, 6, 1, 2);
        prog[6] = HALT;
        run(cyc);
        rdreg(1, v); chk("R2 addi", v, a & 16'hFFFF);
        rdreg(3, v); chk("R2 add", v, (a + b) & 16'hFFFF);
        rdreg(4, v); chk("R2 sub", v, (a - b) & 16'hFFFF);
        rdreg(5, v); chk("R2 and", v, (a & b) & 16'hFFFF);
        rdreg(6, v); chk("R2 or", v, (a | b) & 16'hFFFF);
      end
    end

    // R1: reset clears registers and halted
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R1 halted low", int'(halted), 0);
    for (int r = 0; r < 8; r++) begin rdreg(r, v); chk("R1 reg zero", v, 0); end

    // R3: register zero
    clear_prog();
    prog[0] = ri(ADDI, 0, 0, 5);
    prog[1] = rr(ADD, 1, 0, 0);
    prog[2] = ri(ADDI, 2, 0, -1);
    prog[3] = ri(LD, 0, 0, 5);
    prog[4] = rr(ADD, 3, 0, 0);
    prog[5] = HALT;
    run(cyc);
    rdreg(0, v); chk("R3 r0", v, 0);
    rdreg(1, v); chk("R3 add r0", v, 0);
    rdreg(2, v); chk("R3 neg imm", v, 16'hFFFF);
    rdreg(3, v); chk("R3 load r0", v, 0);

    // R4: jump with delay slot
    clear_prog();
    prog[0] = ri(ADDI, 1, 0, 1);
    prog[1] = jp(5);
    prog[2] = ri(ADDI, 2, 0, 2);
    prog[3] = ri(ADDI, 3, 0, 3);
    prog[4] = ri(ADDI, 4, 0, 4);
    prog[5] = ri(ADDI, 5, 0, 5);
    prog[6] = HALT;
    run(cyc);
    rdreg(2, v); chk("R4 slot runs", v, 2);
    rdreg(3, v); chk("R4 skipped", v, 0);
    rdreg(4, v); chk("R4 skipped", v, 0);
    rdreg(5, v); chk("R4 target", v, 5);

    // R5: taken and not-taken branch
    clear_prog();
    prog[0] = ri(ADDI, 1, 0, 7);
    prog[1] = ri(ADDI, 2, 0, 7);
    prog[2] = ri(BEQ, 1, 2, 4);
    prog[3] = ri(ADDI, 3, 0, 1);
    prog[4] = ri(ADDI, 4, 0, 1);
    prog[5] = HALT;
    prog[6] = ri(BEQ, 1, 0, 3);
    prog[7] = ri(ADDI, 5, 0, 1);
    prog[8] = ri(ADDI, 6, 0, 1);
    prog[9] = HALT;
    run(cyc);
    rdreg(3, v); chk("R5 slot taken", v, 1);
    rdreg(4, v); chk("R5 skipped", v, 0);
    rdreg(5, v); chk("R5 slot not taken", v, 1);
    rdreg(6, v); chk("R5 fallthrough", v, 1);

    // R5: loop with a negative branch offset
    clear_prog();
    prog[0] = ri(ADDI, 1, 0, 3);
    prog[1] = ri(ADDI, 2, 2, 1);
    prog[2] = ri(ADDI, 1, 1, -1);
    prog[3] = ri(BEQ, 1, 0, 4);
    prog[4] = ri(ADDI, 3, 3, 2);
    prog[5] = ri(BEQ, 0, 0, -4);
    prog[6] = ri(ADDI, 4, 4, 1);
    prog[7] = HALT;
    run(cyc);
    rdreg(2, v); chk("R5 loop body", v, 3);
    rdreg(3, v); chk("R5 exit slot", v, 6);
    rdreg(4, v); chk("R5 back slot", v, 2);

    // R6, R11: loads, stores, store-to-load
    clear_prog();
    prog[0] = ri(ADDI, 1, 0, 10);
    prog[1] = ri(LD, 2, 1, 2);
    prog[2] = ri(ST, 2, 0, 20);
    prog[3] = ri(LD, 3, 0, 20);
    prog[4] = ri(LD, 4, 1, -3);
    prog[5] = HALT;
    run(cyc);
    rdreg(2, v); chk("R6 load", v, mval(12));
    rdmem(20, v); chk("R6 store", v, mval(12));
    rdreg(3, v); chk("R11 store then load", v, mval(12));
    rdreg(4, v); chk("R6 neg offset", v, mval(7));

    // R7: load-use distance
    clear_prog();
    prog[0] = ri(LD, 1, 0, 5); prog[1] = rr(ADD, 2, 1, 1);
    prog[2] = ri(ADDI, 3, 0, 1); prog[3] = ri(ADDI, 4, 0, 1); prog[4] = HALT;
    run(ca);
    rdreg(2, v); chk("R7 dependent value", v, 2 * mval(5));
    clear_prog();
    prog[0] = ri(LD, 1, 0, 5); prog[1] = ri(ADDI, 3, 0, 1);
    prog[2] = ri(ADDI, 4, 0, 1); prog[3] = rr(ADD, 2, 1, 1); prog[4] = HALT;
    run(cb);
    rdreg(2, v); chk("R7 distant value", v, 2 * mval(5));
    clear_prog();
    prog[0] = ri(LD, 1, 0, 5); prog[1] = ri(ADDI, 3, 0, 1);
    prog[2] = rr(ADD, 2, 1, 1); prog[3] = ri(ADDI, 4, 0, 1); prog[4] = HALT;
    run(cc);
    clear_prog();
    prog[0] = ri(ADDI, 1, 0, 1); prog[1] = ri(ADDI, 3, 0, 1);
    prog[2] = ri(ADDI, 4, 0, 1); prog[3] = rr(ADD, 2, 1, 1); prog[4] = HALT;
    run(cd);
    chk("R7 adjacent stall", ca - cb, 2);
    chk("R7 one-gap stall", cc - cb, 1);
    chk("R7 two-gap no stall", cb, cd);

    // R8: back-to-back ALU dependence costs nothing
    clear_prog();
    prog[0] = ri(ADDI, 1, 0, 5); prog[1] = rr(ADD, 2, 1, 1);
    prog[2] = rr(ADD, 3, 2, 1); prog[3] = HALT;
    run(cf);
    rdreg(3, v); chk("R8 chain value", v, 15);
    clear_prog();
    prog[0] = ri(ADDI, 1, 0, 5); prog[1] = ri(ADDI, 2, 0, 1);
    prog[2] = ri(ADDI, 3, 0, 1); prog[3] = HALT;
    run(cg);
    chk("R8 no stall", cf, cg);

    // R10: ALU overwrite of a locked target
    clear_prog();
    prog[0] = ri(LD, 1, 0, 5); prog[1] = ri(ADDI, 1, 0, 9); prog[2] = HALT;
    run(cyc);
    rdreg(1, v); chk("R10 younger write wins", v, 9);

    // R9: halt
    clear_prog();
    prog[0] = ri(ADDI, 2, 0, 3); prog[1] = HALT;
    prog[2] = ri(ADDI, 1, 0, 1); prog[3] = ri(ST, 2, 0, 30);
    run(cyc);
    chk("R9 halted", int'(halted), 1);
    repeat (20) @(negedge clk);
    chk("R9 halted stays", int'(halted), 1);
    rdreg(1, v); chk("R9 after halt", v, 0);
    rdreg(2, v); chk("R9 before halt", v, 3);
    rdmem(30, v); chk("R9 no store", v, mval(30));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule